// File: doc/BRIEF.md
# Interrupt Pending and Mask Unit

This block gathers 32 interrupt request lines for a small processor core and keeps a vector of pending requests. Parameters fix each line's behaviour. A line can be latched, so that a single-cycle pulse is remembered until the handler runs. A line can instead be level sensitive, so that its pending state tracks the wire. A line can also be switched off for good. Two internal trap sources, a breakpoint and an unclaimed illegal instruction, raise one fixed low-numbered bit.

The core sees one request output. It also sees the unmasked pending vector, which it hands to its handler. A runtime mask register, written by the core, selects which pending bits may raise the request. When the core enters the handler, the bits it was shown are cleared and an active flag is set. While that flag is set, no new request is raised. A return strobe clears the flag. The handler start address is a parameter, brought out on a port.

Top module: `irq_pend_unit`

## Requirements
- R1: After reset, no bit is pending, the active flag is 0, the request is 0 and every runtime mask bit is 1.
- R2: A latched line (bit of LATCH_SEL equal to 1) that is high for one cycle becomes pending from the next cycle on. It stays pending until it is delivered at handler entry.
- R3: A level line (bit of LATCH_SEL equal to 0) is pending in a cycle exactly when its input was high in the cycle before. Nothing is held after the input drops.
- R4: A line whose PERM_MASK bit is 1 never shows as pending and never raises the request.
- R5: Either a breakpoint strobe or an illegal-instruction strobe raises line TRAP_BIT (default 1), as if that line had been driven high in the same cycle.
- R6: The runtime mask is written with mask_wdata on the cycle after mask_we. irq_pending_out equals the pending vector AND the inverted runtime mask. A bit masked at runtime stays pending and shows once it is unmasked.
- R7: On a handler_enter cycle, the bits shown on irq_pending_out are cleared at the next edge. A latched line pulsing in that same cycle stays pending.
- R8: irq_active is set the cycle after handler_enter and cleared the cycle after handler_return, with entry winning when both occur together. irq_req is 1 exactly when irq_pending_out is non-zero and irq_active is 0.
- R9: handler_addr always equals the HANDLER_ADDR parameter (default 0x0000_0010).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | External request lines, bit i is line i |
| brk_trap | input | 1 | Breakpoint trap strobe |
| ill_trap | input | 1 | Unclaimed illegal-instruction strobe |
| mask_we | input | 1 | Runtime mask write enable |
| mask_wdata | input | 32 | New runtime mask, 1 blocks a line |
| handler_enter | input | 1 | Core enters the handler this cycle |
| handler_return | input | 1 | Core returns from the handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_pending_out | output | 32 | Unmasked pending vector for the handler |
| irq_active | output | 1 | Handler is running |
| handler_addr | output | 32 | Handler start address |

## Verification
Each input takes effect at the next rising edge. Pending bits, the runtime mask and the active flag are all registers. So a pulse, a mask write, an entry or a return driven in one cycle shows on irq_pending_out, irq_req and irq_active in the following cycle. There is no further delay, because the outputs are plain logic on those registers. The bench drives inputs at the falling edge, steps a requirement-level model at the rising edge and compares all outputs at the next falling edge. Every result is therefore checked in the cycle it is due, under both directed corner cases and seeded random traffic.

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter logic [31:0] PERM_MASK    = 32'h0000_0000,
  parameter logic [31:0] LATCH_SEL    = 32'hFFFF_FFFF,
  parameter logic [31:0] HANDLER_ADDR = 32'h0000_0010,
  parameter int          TRAP_BIT     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_lines,
  input  logic        brk_trap,
  input  logic        ill_trap,
  input  logic        mask_we,
  input  logic [31:0] mask_wdata,
  input  logic        handler_enter,
  input  logic        handler_return,
  output logic        irq_req,
  output logic [31:0] irq_pending_out,
  output logic        irq_active,
  output logic [31:0] handler_addr
);
  localparam logic [31:0] TRAP_VEC = 32'h1 << TRAP_BIT;

  logic [31:0] pend_q, mask_q;
  logic        act_q;

  wire [31:0] src   = (irq_lines | ((brk_trap | ill_trap) ? TRAP_VEC : 32'h0)) & ~PERM_MASK;
  wire [31:0] shown = pend_q & ~mask_q;
  wire [31:0] clr   = handler_enter ? shown : 32'h0;
  wire [31:0] nxt   = (((pend_q & ~clr) | src) & LATCH_SEL) | (src & ~LATCH_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      act_q  <= 1'b0;
    end else begin
      pend_q <= nxt;
      if (mask_we) mask_q <= mask_wdata;
      if (handler_enter)       act_q <= 1'b1;
      else if (handler_return) act_q <= 1'b0;
    end
  end

  assign irq_pending_out = shown;
  assign irq_req         = (|shown) & ~act_q;
  assign irq_active      = act_q;
  assign handler_addr    = HANDLER_ADDR;
endmodule

module irq_pend_unit_chk #(
  parameter logic [31:0] PERM_MASK = 32'h0,
  parameter logic [31:0] LATCH_SEL = 32'hFFFF_FFFF,
  parameter int          TRAP_BIT  = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] irq_lines,
  input logic        brk_trap,
  input logic        ill_trap,
  input logic        handler_enter,
  input logic        handler_return,
  input logic        irq_req,
  input logic        irq_active,
  input logic [31:0] irq_pending_out,
  input logic [31:0] pend_q
);
  localparam logic [31:0] TV = 32'h1 << TRAP_BIT;
  wire [31:0] drv = irq_lines | ((brk_trap | ill_trap) ? TV : 32'h0);

  assert_perm_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending_out & PERM_MASK) == 32'h0);
  assert_active_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_active |-> !irq_req);
  assert_enter_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    handler_enter |=> irq_active);
  assert_return_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_return && !handler_enter) |=> !irq_active);
  assert_latch_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |(drv & LATCH_SEL & ~PERM_MASK) |=>
      ((pend_q & $past(drv & LATCH_SEL & ~PERM_MASK)) == $past(drv & LATCH_SEL & ~PERM_MASK)));
  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & ~LATCH_SEL) == ($past(drv) & ~LATCH_SEL & ~PERM_MASK)));
endmodule

bind irq_pend_unit irq_pend_unit_chk #(
  .PERM_MASK(PERM_MASK), .LATCH_SEL(LATCH_SEL), .TRAP_BIT(TRAP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .brk_trap(brk_trap),
  .ill_trap(ill_trap), .handler_enter(handler_enter), .handler_return(handler_return),
  .irq_req(irq_req), .irq_active(irq_active), .irq_pending_out(irq_pending_out),
  .pend_q(pend_q)
);

// File: tb/irq_pend_unit_test.sv
module irq_pend_unit_test;
  localparam logic [31:0] PM = 32'h0000_F000;
  localparam logic [31:0] LS = 32'hFFFF_00FF;
  localparam logic [31:0] HA = 32'h0000_0010;

  logic clk = 0, rst_n = 0;
  logic [31:0] irq_lines = 0, mask_wdata = 0;
  logic brk_trap = 0, ill_trap = 0, mask_we = 0, handler_enter = 0, handler_return = 0;
  logic irq_req, irq_active;
  logic [31:0] irq_pending_out, handler_addr;

  int tests = 0, fails = 0;
  logic [31:0] m_pend, m_mask;
  logic m_act;

  always #2.5 clk = ~clk;

  irq_pend_unit #(.PERM_MASK(PM), .LATCH_SEL(LS), .HANDLER_ADDR(HA)) uut (.*);

  function automatic logic [31:0] exp_shown();
    return m_pend & ~m_mask;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " pending"}, irq_pending_out, exp_shown());
    chk({tag, " req R8"}, {31'h0, irq_req}, {31'h0, (|exp_shown()) & ~m_act});
    chk({tag, " active R8"}, {31'h0, irq_active}, {31'h0, m_act});
  endtask

  task automatic step(input logic [31:0] ln, input logic bk, input logic il,
                      input logic we, input logic [31:0] wd, input logic en, input logic rt);
    logic [31:0] src, clr, np;
    irq_lines = ln; brk_trap = bk; ill_trap = il; mask_we = we; mask_wdata = wd;
    handler_enter = en; handler_return = rt;
    src = (ln | ((bk | il) ? 32'h2 : 32'h0)) & ~PM;
    clr = en ? exp_shown() : 32'h0;
    np  = (((m_pend & ~clr) | src) & LS) | (src & ~LS);
    @(posedge clk);
    m_pend = np;
    if (we) m_mask = wd;
    if (en) m_act = 1'b1; else if (rt) m_act = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_pend = 0; m_mask = '1; m_act = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pending", irq_pending_out, 32'h0);
    chk("R1 req", {31'h0, irq_req}, 32'h0);
    chk("R1 active", {31'h0, irq_active}, 32'h0);
    chk("R9 addr", handler_addr, 32'h0000_0010);

    step(32'h8, 0, 0, 0, 0, 0, 0);
    chk("R6 masked at reset", irq_pending_out, 32'h0);
    chk("R6 no req", {31'h0, irq_req}, 32'h0);
    step(0, 0, 0, 1, 32'h0, 0, 0);
    chk("R6 unmask shows held bit", irq_pending_out, 32'h8);
    idle();
    chk("R2 pulse held", irq_pending_out, 32'h8);
    chk("R8 req up", {31'h0, irq_req}, 32'h1);

    step(32'h200, 0, 0, 0, 0, 0, 0);
    chk("R3 level high", irq_pending_out, 32'h208);
    idle();
    chk("R3 level dropped", irq_pending_out, 32'h8);

    step(32'h2000, 0, 0, 0, 0, 0, 0);
    chk("R4 perm masked", irq_pending_out, 32'h8);

    step(0, 1, 0, 0, 0, 0, 0);
    chk("R5 breakpoint", irq_pending_out, 32'ha);

    step(32'h20, 0, 0, 0, 0, 1, 0);
    chk("R7 clear with new pulse", irq_pending_out, 32'h20);
    chk("R8 active set", {31'h0, irq_active}, 32'h1);
    chk("R8 req blocked", {31'h0, irq_req}, 32'h0);

    step(0, 0, 1, 0, 0, 0, 1);
    chk("R5 illegal", irq_pending_out, 32'h22);
    chk("R8 return", {31'h0, irq_active}, 32'h0);
    chk("R8 req again", {31'h0, irq_req}, 32'h1);

    step(0, 0, 0, 0, 0, 1, 1);
    chk("R8 enter wins", {31'h0, irq_active}, 32'h1);
    chk("R7 all cleared", irq_pending_out, 32'h0);
    step(0, 0, 0, 0, 0, 0, 1);
    check_all("R8 directed");

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ln;
      ln = $urandom & $urandom & $urandom;
      step(ln, ($urandom % 16) == 0, ($urandom % 16) == 0,
           ($urandom % 16) == 0, $urandom & $urandom,
           ($urandom % 8) == 0, ($urandom % 8) == 0);
      check_all("R2 R3 R6 R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule